// File: doc/BRIEF.md
# Reversed Segment Round-Robin Splitter

This block turns a byte-serial memory image into per-block bit streams for a later placement stage. Bytes arrive on a valid/ready channel, each tagged with its address. The block packs the image into segments of 2^a bits. It emits every segment in reverse bit order, one bit per clock. Consecutive segments are dealt across 2^n memory blocks in rotation. Each emitted bit carries three values: the block it belongs to, its running position in that block's own list, and its value.

A start pulse loads the configuration and clears all running state: the segment size exponent, the block count exponent, and the first and last image addresses. From then on the block tracks the next address it expects. Addresses inside the window that never arrive are filled with zero bytes. Repeated or stale addresses are consumed and dropped. A segment left unfinished at the end of the window is padded with zeros. A done flag marks the end of the image.

Top module: `seg_rr_splitter`

## Requirements
- R1: After reset and before the first start pulse, in_ready, out_valid and done are all low, whatever the input channel carries.
- R2: A start pulse latches the configuration, clears every block's bit counter and makes the first image address the expected one. The first bit emitted after start has block 0 and index 0.
- R3: A segment holds 2^A bits, where A is cfg_seg_log2 clamped to the range 3..6 (values below 3 act as 3, above 6 as 6). Exactly 2^A output bits are emitted per segment, and no others.
- R4: The bits of a segment are numbered p = 0..2^A-1. Bit p is bit (7 - p mod 8) of the segment's byte (p div 8), so byte 0 bit 7 is position 0. The e-th bit emitted for the segment is position 2^A-1-e.
- R5: The block count is 2^N, where N is cfg_blk_log2 clamped to at most 4. Segment k of the image (counted from 0 after start) is emitted with out_blk = k mod 2^N.
- R6: out_bit_idx equals the number of bits already emitted for the same block since the last start.
- R7: When the offered address is above the expected address (and the expected address is not past the last address), in_ready stays low. A zero byte is inserted for the expected address, then the expected address moves up by one.
- R8: A byte whose address is below the expected address is accepted (in_ready high) and discarded. It does not alter the image.
- R9: If the last image byte leaves a segment partly filled, zero bytes are appended until the segment is complete. An offered byte above the last address first causes zero fill up to the last address and is itself never accepted.
- R10: done rises on the cycle after the last bit of the image is emitted. It stays high until the next start, and in_ready is low while done is high.
- R11: While a segment is emitted, in_ready is low and its bits appear on consecutive cycles with out_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads configuration and restarts the image |
| cfg_seg_log2 | input | CFG_W (3) | Segment size exponent A (clamped 3..6) |
| cfg_blk_log2 | input | CFG_W (3) | Block count exponent N (clamped to 4) |
| cfg_base_addr | input | ADDR_W (16) | Address of the first image byte |
| cfg_high_addr | input | ADDR_W (16) | Address of the last image byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte consumed this cycle when in_valid is also high |
| in_addr | input | ADDR_W (16) | Address of the offered byte |
| in_data | input | 8 | Offered byte |
| out_valid | output | 1 | An output bit is present |
| out_blk | output | MAX_BLK_LOG2 (4) | Target block of the bit |
| out_bit_idx | output | IDX_W (16) | Position of the bit in the target block's list |
| out_bit | output | 1 | Bit value |
| done | output | 1 | Whole image emitted |

## Verification
The hardest situation to reach is a zero-filled or duplicated address that falls in the middle of a segment, or that meets a segment still being emitted. The most awkward case is a missing last address, which only a byte beyond the window can trigger. The stimulus walks every address of the window and drops or repeats addresses by an arithmetic rule. It always ends with a byte past the last address. This is swept over every segment size and every block count, plus out-of-range settings, so that gaps, repeats and padding land at every offset within a segment.

// File: rtl/seg_rr_pkg.sv
package seg_rr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_EMIT = 2'd2,
      ST_DONE = 2'd3
   } spl_state_e;

   localparam int MIN_SEG_LOG2 = 3;
   localparam int BYTE_W       = 8;

endpackage

// File: rtl/seg_gather.sv
module seg_gather #(
   parameter int MAX_SEG_LOG2 = 6,
   localparam int BCNT_W      = MAX_SEG_LOG2 - 3,
   localparam int NUM_SLOTS   = 1 << BCNT_W,
   localparam int SEG_BITS    = 1 << MAX_SEG_LOG2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                push,
   input  logic [7:0]          din,
   input  logic [BCNT_W-1:0]   bytes_m1,
   output logic [BCNT_W-1:0]   bcnt,
   output logic                last_push,
   output logic [SEG_BITS-1:0] seg_bits
);

   logic [BCNT_W-1:0] bcnt_q;
   logic [7:0]        slot_q [NUM_SLOTS];

   assign bcnt      = bcnt_q;
   assign last_push = push && (bcnt_q == bytes_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
      end else if (clr || last_push) begin
         bcnt_q <= '0;
      end else if (push) begin
         bcnt_q <= bcnt_q + BCNT_W'(1);
      end
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[k] <= '0;
         end else if (push && !clr && (bcnt_q == BCNT_W'(k))) begin
            slot_q[k] <= din;
         end
      end
      // position p of the segment is bit (7 - p mod 8) of byte p div 8
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign seg_bits[k*8 + i] = slot_q[k][7-i];
      end
   end

   // R3: the byte counter never passes the configured segment length
   p_bcnt_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !$past(clr)) |-> (bcnt_q <= bytes_m1));

endmodule

// File: rtl/seg_pick.sv
module seg_pick #(
   parameter int MAX_SEG_LOG2 = 6,
   localparam int SEG_BITS    = 1 << MAX_SEG_LOG2
) (
   input  logic [SEG_BITS-1:0]     seg_bits,
   input  logic [MAX_SEG_LOG2-1:0] len_m1,
   input  logic [MAX_SEG_LOG2-1:0] emit_idx,
   output logic                    bit_out
);

   logic [MAX_SEG_LOG2-1:0] pos;

   always_comb begin
      pos     = len_m1 - emit_idx;
      bit_out = seg_bits[pos];
   end

endmodule

// File: rtl/blk_counters.sv
module blk_counters #(
   parameter int BLK_W     = 4,
   parameter int IDX_W     = 16,
   localparam int NUM_BLK  = 1 << BLK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [BLK_W-1:0] sel,
   output logic [IDX_W-1:0] idx
);

   logic [IDX_W-1:0] cnt_q [NUM_BLK];

   for (genvar k = 0; k < NUM_BLK; k++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q[k] <= '0;
         end else if (clr) begin
            cnt_q[k] <= '0;
         end else if (inc && (sel == BLK_W'(k))) begin
            cnt_q[k] <= cnt_q[k] + IDX_W'(1);
         end
      end

      // R6: a block's count moves only for bits routed to that block
      p_cnt_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !(inc && (sel == BLK_W'(k)))) |=> $stable(cnt_q[k]));
   end

   assign idx = cnt_q[sel];

endmodule

// File: rtl/seg_rr_splitter.sv
module seg_rr_splitter
   import seg_rr_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int IDX_W        = 16,
   parameter int MAX_SEG_LOG2 = 6,
   parameter int MAX_BLK_LOG2 = 4,
   parameter int CFG_W        = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [CFG_W-1:0]        cfg_seg_log2,
   input  logic [CFG_W-1:0]        cfg_blk_log2,
   input  logic [ADDR_W-1:0]       cfg_base_addr,
   input  logic [ADDR_W-1:0]       cfg_high_addr,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [ADDR_W-1:0]       in_addr,
   input  logic [7:0]              in_data,
   output logic                    out_valid,
   output logic [MAX_BLK_LOG2-1:0] out_blk,
   output logic [IDX_W-1:0]        out_bit_idx,
   output logic                    out_bit,
   output logic                    done
);

   localparam int BCNT_W   = MAX_SEG_LOG2 - 3;
   localparam int EIDX_W   = MAX_SEG_LOG2;
   localparam int BLK_W    = MAX_BLK_LOG2;
   localparam int SEG_BITS = 1 << MAX_SEG_LOG2;
   localparam int XA_W     = ADDR_W + 1;

   initial begin
      assert (MAX_SEG_LOG2 >= 4) else $error("MAX_SEG_LOG2 below 4");
      assert (MAX_BLK_LOG2 >= 1) else $error("MAX_BLK_LOG2 below 1");
      assert ((1 << CFG_W) > MAX_SEG_LOG2) else $error("CFG_W too narrow for segment exponent");
      assert ((1 << CFG_W) > MAX_BLK_LOG2) else $error("CFG_W too narrow for block exponent");
      assert (ADDR_W >= 1 && IDX_W >= 1) else $error("bad widths");
   end

   spl_state_e        state_q;
   logic [CFG_W-1:0]  a_q, bl_q, a_in, bl_in;
   logic [XA_W-1:0]   high_q, exp_q, addr_ext;
   logic [EIDX_W-1:0] emit_q, seg_len_m1;
   logic [BLK_W-1:0]  seg_q, blk_mask;
   logic [BCNT_W-1:0] seg_bytes_m1, bcnt;
   logic [SEG_BITS-1:0] seg_bits;
   logic              exp_past, push, adv, last_push, emit_last;
   logic [7:0]        push_byte;

   // configuration clamp
   always_comb begin
      if (cfg_seg_log2 < CFG_W'(MIN_SEG_LOG2))      a_in = CFG_W'(MIN_SEG_LOG2);
      else if (cfg_seg_log2 > CFG_W'(MAX_SEG_LOG2)) a_in = CFG_W'(MAX_SEG_LOG2);
      else                                          a_in = cfg_seg_log2;
      if (cfg_blk_log2 > CFG_W'(MAX_BLK_LOG2))      bl_in = CFG_W'(MAX_BLK_LOG2);
      else                                          bl_in = cfg_blk_log2;
   end

   // derived geometry of the latched configuration
   always_comb begin
      seg_len_m1   = EIDX_W'((32'd1 << a_q) - 32'd1);
      seg_bytes_m1 = BCNT_W'((32'd1 << (a_q - CFG_W'(MIN_SEG_LOG2))) - 32'd1);
      blk_mask     = BLK_W'((32'd1 << bl_q) - 32'd1);
   end

   assign addr_ext  = {1'b0, in_addr};
   assign exp_past  = exp_q > high_q;
   assign emit_last = (emit_q == seg_len_m1);

   // address tracker: real byte, zero fill, or trailing pad
   always_comb begin
      push      = 1'b0;
      push_byte = '0;
      if (state_q == ST_FILL) begin
         if (exp_past) begin
            push = (bcnt != '0);
         end else if (in_valid && (addr_ext >= exp_q)) begin
            push      = 1'b1;
            push_byte = (addr_ext == exp_q) ? in_data : 8'h00;
         end
      end
      adv = push && !exp_past;
   end

   assign in_ready = (state_q == ST_FILL) && !exp_past && (addr_ext <= exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         a_q     <= CFG_W'(MIN_SEG_LOG2);
         bl_q    <= '0;
         high_q  <= '0;
         exp_q   <= '0;
         emit_q  <= '0;
         seg_q   <= '0;
      end else if (start) begin
         state_q <= ST_FILL;
         a_q     <= a_in;
         bl_q    <= bl_in;
         high_q  <= {1'b0, cfg_high_addr};
         exp_q   <= {1'b0, cfg_base_addr};
         emit_q  <= '0;
         seg_q   <= '0;
      end else begin
         unique case (state_q)
            ST_FILL: begin
               if (adv) exp_q <= exp_q + XA_W'(1);
               if (last_push) begin
                  state_q <= ST_EMIT;
                  emit_q  <= '0;
               end else if (exp_past && (bcnt == '0)) begin
                  state_q <= ST_DONE;
               end
            end
            ST_EMIT: begin
               if (emit_last) begin
                  emit_q  <= '0;
                  seg_q   <= seg_q + BLK_W'(1);
                  state_q <= exp_past ? ST_DONE : ST_FILL;
               end else begin
                  emit_q <= emit_q + EIDX_W'(1);
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   seg_gather #(.MAX_SEG_LOG2(MAX_SEG_LOG2)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .push      (push),
      .din       (push_byte),
      .bytes_m1  (seg_bytes_m1),
      .bcnt      (bcnt),
      .last_push (last_push),
      .seg_bits  (seg_bits)
   );

   seg_pick #(.MAX_SEG_LOG2(MAX_SEG_LOG2)) u_pick (
      .seg_bits (seg_bits),
      .len_m1   (seg_len_m1),
      .emit_idx (emit_q),
      .bit_out  (out_bit)
   );

   assign out_valid = (state_q == ST_EMIT);
   assign out_blk   = seg_q & blk_mask;
   assign done      = (state_q == ST_DONE);

   blk_counters #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .inc   (out_valid),
      .sel   (out_blk),
      .idx   (out_bit_idx)
   );

   // R1: quiet until the first start
   p_quiet_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (!in_ready && !out_valid && !done));

   // R2: counters cleared by start
   p_idx_clear_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (out_bit_idx == '0));

   // R2: the expected address never moves back without a start
   p_addr_mono_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (exp_q >= $past(exp_q)));

   // R5: block index stays inside the configured block count
   p_blk_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_blk & ~blk_mask) == '0));

   // R10: done holds until restarted and blocks the input
   p_done_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && !in_ready));

   // R11: no input accepted during emission
   p_ready_low_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R11: emission runs without gaps to the segment end
   p_emit_run_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !emit_last && !start) |=> out_valid);

endmodule

// File: tb/seg_rr_splitter_bench.sv
`timescale 1ns/1ps
module seg_rr_splitter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  cfg_seg_log2 = '0;
   logic [2:0]  cfg_blk_log2 = '0;
   logic [15:0] cfg_base_addr = '0;
   logic [15:0] cfg_high_addr = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_addr = '0;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic [3:0]  out_blk;
   logic [15:0] out_bit_idx;
   logic        out_bit;
   logic        done;

   always #2.5 clk = ~clk;

   seg_rr_splitter u_seg_rr_splitter (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_seg_log2(cfg_seg_log2), .cfg_blk_log2(cfg_blk_log2),
      .cfg_base_addr(cfg_base_addr), .cfg_high_addr(cfg_high_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
      .out_valid(out_valid), .out_blk(out_blk), .out_bit_idx(out_bit_idx),
      .out_bit(out_bit), .done(done)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   bit e_bit  [1024];
   int e_blk  [1024];
   int e_idx  [1024];
   int e_kind [1024]; // 0 data, 1 gap fill, 2 pad, 3 repeated address
   int n_exp = 0;
   int pos = 0;
   int seg_sz = 8;
   bit mon_on = 0;
   int last_v_cyc = -10;
   bit done_prev = 0;

   task automatic chk(bit ok, string tag, longint act, longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic bit is_gap(int addr);
      return ((addr ^ (addr >> 2)) % 5) == 0;
   endfunction

   function automatic bit is_dup(int addr);
      return (addr % 6) == 3;
   endfunction

   function automatic logic [7:0] data_of(int addr, int a, int bl);
      return 8'((addr * 37 + a * 11 + bl * 3 + 5) & 255);
   endfunction

   // output monitor, sampled away from the rising edge
   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (out_valid) begin
            chk(in_ready == 1'b0, "R11 ready low while emitting", in_ready, 0);
            if (pos < n_exp) begin
               case (e_kind[pos])
                  1: chk(out_bit == e_bit[pos], "R7 zero fill bit", out_bit, e_bit[pos]);
                  2: chk(out_bit == e_bit[pos], "R9 pad bit", out_bit, e_bit[pos]);
                  3: chk(out_bit == e_bit[pos], "R8 repeat dropped bit", out_bit, e_bit[pos]);
                  default: chk(out_bit == e_bit[pos], "R4 reversed bit", out_bit, e_bit[pos]);
               endcase
               chk(out_blk == 4'(e_blk[pos]), "R5 block", out_blk, e_blk[pos]);
               chk(out_bit_idx == 16'(e_idx[pos]), "R6 index", out_bit_idx, e_idx[pos]);
               if (pos == 0)
                  chk(out_blk == 0 && out_bit_idx == 0, "R2 first bit block 0 index 0",
                      out_bit_idx, 0);
               if ((pos % seg_sz) != 0)
                  chk(last_v_cyc == cyc - 1, "R11 consecutive bits", cyc - last_v_cyc, 1);
            end else begin
               chk(1'b0, "R3 extra output bit", pos + 1, n_exp);
            end
            pos++;
            last_v_cyc = cyc;
         end
         if (done && !done_prev)
            chk(last_v_cyc == cyc - 1, "R10 done timing", cyc - last_v_cyc, 1);
         done_prev = done;
      end
   end

   // offer one byte, starting at a falling edge; give up once done is seen
   task automatic send_byte(int addr, logic [7:0] d);
      bit r, dn;
      in_valid = 1'b1;
      in_addr  = 16'(addr);
      in_data  = d;
      do begin
         #1;
         r  = in_ready;
         dn = done;
         @(negedge clk);
      end while (!r && !dn);
   endtask

   task automatic run_case(int a_cfg, int bl_cfg, int base, int len);
      int a_eff, sbits, nblk, padded, nseg, w;
      logic [7:0] img [64];
      int kind [64];
      int cnt [16];
      a_eff  = (a_cfg < 3) ? 3 : ((a_cfg > 6) ? 6 : a_cfg);
      sbits  = 1 << a_eff;
      nblk   = 1 << ((bl_cfg > 4) ? 4 : bl_cfg);
      padded = ((len * 8 + sbits - 1) / sbits) * (sbits / 8);
      nseg   = padded * 8 / sbits;
      for (int o = 0; o < 64; o++) begin
         img[o]  = 8'h00;
         kind[o] = (o < len) ? 1 : 2;
      end
      for (int o = 0; o < len; o++) begin
         if (!is_gap(base + o)) begin
            img[o]  = data_of(base + o, a_cfg, bl_cfg);
            kind[o] = is_dup(base + o) ? 3 : 0;
         end
      end
      for (int b = 0; b < 16; b++) cnt[b] = 0;
      n_exp = 0;
      for (int k = 0; k < nseg; k++) begin
         for (int e = 0; e < sbits; e++) begin
            int p, byi;
            p   = sbits - 1 - e;
            byi = k * (sbits / 8) + p / 8;
            e_bit[n_exp]  = img[byi][7 - (p % 8)];
            e_kind[n_exp] = kind[byi];
            e_blk[n_exp]  = k % nblk;
            e_idx[n_exp]  = cnt[k % nblk];
            cnt[k % nblk]++;
            n_exp++;
         end
      end
      seg_sz = sbits;

      @(negedge clk);
      cfg_seg_log2  = 3'(a_cfg);
      cfg_blk_log2  = 3'(bl_cfg);
      cfg_base_addr = 16'(base);
      cfg_high_addr = 16'(base + len - 1);
      start = 1'b1;
      pos = 0;
      last_v_cyc = -10;
      mon_on = 1;
      @(negedge clk);
      start = 1'b0;
      for (int o = 0; o < len; o++) begin
         if (!is_gap(base + o)) begin
            send_byte(base + o, data_of(base + o, a_cfg, bl_cfg));
            if (is_dup(base + o)) send_byte(base + o, data_of(base + o, a_cfg, bl_cfg) ^ 8'h5A);
         end
      end
      send_byte(base + len, 8'hEE);
      in_valid = 1'b0;
      w = 0;
      while (!done && w < 3000) begin
         @(negedge clk);
         w++;
      end
      chk(done == 1'b1, "R10 done reached", done, 1);
      @(negedge clk);
      @(negedge clk);
      chk(pos == n_exp, "R3 bit count", pos, n_exp);
      chk(in_ready == 1'b0 && done == 1'b1, "R10 done holds with ready low", in_ready, 0);
   endtask

   initial begin
      #(150000 * 5);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int cs;
      in_valid = 1'b1;
      in_addr  = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R1 ready low before start", in_ready, 0);
      chk(out_valid == 1'b0, "R1 no output before start", out_valid, 0);
      chk(done == 1'b0, "R1 done low before start", done, 0);
      in_valid = 1'b0;
      cs = 0;
      for (int a = 3; a <= 6; a++) begin
         for (int bl = 0; bl <= 4; bl++) begin
            run_case(a, bl, 16'h0100 + 37 * cs, 13 + (cs % 9));
            cs++;
         end
      end
      // clamped settings, R3 and R5
      run_case(1, 7, 16'h0800, 17);
      run_case(7, 5, 16'h0900, 21);
      run_case(0, 6, 16'h0A03, 14);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule